// File: doc/BRIEF.md
# Dual-Path Register Dependency Scoreboard

This block tracks outstanding register writes for one warp on a core that can issue from both sides of a divergent branch at the same time. It holds two scoreboards, one per path. Every register has two flags in each scoreboard. The pending flag marks a write issued by that path. The shadow flag marks a write that was already outstanding when the warp split. An instruction from one path waits on its own pending flags and on the other path's shadow flags. Writes that one path issues after the split therefore never stall the other path. Writes left over from before the split still stall both paths.

While the warp is converged, one scoreboard is live. It is called the home path, and every request is steered to it whatever path tag the request carries. A divergence event snapshots each path's pending flags into its shadow flags and opens dual-path mode. A reconvergence event folds both pending sets into the scoreboard named by the event, clears the other one and every shadow flag, and makes that path the new home. Each writeback carries a one-bit path tag that picks the scoreboard it clears.

Top module: `dual_path_scoreboard`

## Requirements
- R1: After reset, no register is pending or shadowed, `diverged` is 0, `home_path` is 0 and `chk_ok` is 1 for any operands.
- R2: A reservation (`rsv_valid`) sets the pending flag of `rsv_reg` in the selected scoreboard from the next cycle. A check on the same path that names that register as any operand then returns `chk_ok` = 0.
- R3: A writeback (`wb_valid`) clears both the pending flag and the shadow flag of `wb_reg` in the selected scoreboard from the next cycle.
- R4: On an accepted divergence event, each path's shadow flags take that path's pending flags, including reservations and writebacks of the same cycle. From the next cycle the other path is blocked on those registers until they are written back.
- R5: While diverged, a reservation by one path never blocks a check from the other path, and no shadow flag is ever set.
- R6: While diverged, a path is still blocked by its own pending flags, including those held from before the split.
- R7: While converged (`diverged` = 0), the `chk_path`, `rsv_path` and `wb_path` inputs are ignored and every operation uses `home_path`.
- R8: An accepted reconvergence event gives scoreboard `reconv_path` the OR of both paths' pending flags, clears the other scoreboard and all shadow flags, and sets `home_path` to `reconv_path`.
- R9: When a reservation and a writeback name the same register of the same scoreboard in the same cycle, the register stays pending.
- R10: A divergence event while diverged, and a reconvergence event while converged, have no effect.
- R11: `chk_ok` is the AND over all three operands (`chk_src_a`, `chk_src_b`, `chk_dst`). A hazard on any single operand drives it to 0. It depends on the current state only, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_path | input | 1 | Path of the instruction being checked |
| chk_src_a | input | REG_W | First source register |
| chk_src_b | input | REG_W | Second source register |
| chk_dst | input | REG_W | Destination register |
| chk_ok | output | 1 | 1 when the checked instruction has no hazard |
| rsv_valid | input | 1 | Reserve a destination at issue |
| rsv_path | input | 1 | Path of the issuing instruction |
| rsv_reg | input | REG_W | Register to mark pending |
| wb_valid | input | 1 | A write is completing |
| wb_path | input | 1 | Path tag carried by the write |
| wb_reg | input | REG_W | Register being written |
| div_event | input | 1 | Warp splits into two paths |
| reconv_event | input | 1 | Paths rejoin |
| reconv_path | input | 1 | Scoreboard that survives the rejoin |
| diverged | output | 1 | 1 while two paths are live |
| home_path | output | 1 | Scoreboard in use while converged |

## Verification
Short directed sequences come first. A reserved register is checked from the same path and from the other path, both before and after a split. The check is made through each of the three operand slots, so a dropped operand or a swapped own/other lookup shows up. A writeback and a reservation on the same register land together, and split and rejoin events are raised in the wrong mode. This separates the clear/set order and the mode guards. A long random run then works on only eight registers so that collisions are frequent. It mixes reservations, tagged writebacks, splits and rejoins to either path. The check result and mode outputs are compared every cycle with a behavioural model, which shows up any error in snapshot timing or merge content.

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic {
      PATH_A = 1'b0,
      PATH_B = 1'b1
   } path_e;

   localparam int unsigned NUM_PATHS = 2;
   localparam int unsigned NUM_OPS   = 3;

   function automatic path_e flip_path(input path_e p);
      return (p == PATH_A) ? PATH_B : PATH_A;
   endfunction

endpackage

// File: rtl/dps_mode_ctrl.sv
module dps_mode_ctrl
   import dps_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  div_event,
   input  logic  reconv_event,
   input  path_e reconv_path,
   output logic  diverged_q,
   output path_e home_q,
   output logic  div_fire,
   output logic  reconv_fire
);

   assign div_fire    = ~diverged_q & div_event;
   assign reconv_fire =  diverged_q & reconv_event;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         diverged_q <= 1'b0;
         home_q     <= PATH_A;
      end else if (div_fire) begin
         diverged_q <= 1'b1;
      end else if (reconv_fire) begin
         diverged_q <= 1'b0;
         home_q     <= reconv_path;
      end
   end

endmodule

// File: rtl/dps_bank.sv
module dps_bank #(
   parameter int unsigned NUM_REGS = 32,
   localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rsv_en,
   input  logic [REG_W-1:0]    rsv_reg,
   input  logic                wb_en,
   input  logic [REG_W-1:0]    wb_reg,
   input  logic                snap,
   input  logic                merge_load,
   input  logic [NUM_REGS-1:0] merge_in,
   input  logic                clear_all,
   output logic [NUM_REGS-1:0] pend_q,
   output logic [NUM_REGS-1:0] shad_q,
   output logic [NUM_REGS-1:0] pend_nxt
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic set_i;
      logic clr_i;
      logic p_r;
      logic s_r;

      assign set_i       = rsv_en & (rsv_reg == REG_W'(i));
      assign clr_i       = wb_en  & (wb_reg  == REG_W'(i));
      assign pend_nxt[i] = (p_r & ~clr_i) | set_i;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            p_r <= 1'b0;
            s_r <= 1'b0;
         end else begin
            if (merge_load)     p_r <= merge_in[i];
            else if (clear_all) p_r <= 1'b0;
            else                p_r <= pend_nxt[i];

            if (merge_load || clear_all) s_r <= 1'b0;
            else if (snap)               s_r <= pend_nxt[i];
            else                         s_r <= s_r & ~clr_i;
         end
      end

      assign pend_q[i] = p_r;
      assign shad_q[i] = s_r;
   end

endmodule

// File: rtl/dps_hazard.sv
module dps_hazard #(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned NUM_OPS  = 3,
   localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0]           own_pend,
   input  logic [NUM_REGS-1:0]           other_shad,
   input  logic [NUM_OPS-1:0][REG_W-1:0] op_regs,
   output logic                          ok
);

   logic [NUM_OPS-1:0] hit;

   for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
      assign hit[k] = own_pend[op_regs[k]] | other_shad[op_regs[k]];
   end

   assign ok = ~|hit;

endmodule

// File: rtl/dual_path_scoreboard.sv
module dual_path_scoreboard
   import dps_pkg::*;
#(
   parameter int unsigned NUM_REGS = 32,
   localparam int unsigned REG_W   = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chk_path,
   input  logic [REG_W-1:0] chk_src_a,
   input  logic [REG_W-1:0] chk_src_b,
   input  logic [REG_W-1:0] chk_dst,
   output logic             chk_ok,
   input  logic             rsv_valid,
   input  logic             rsv_path,
   input  logic [REG_W-1:0] rsv_reg,
   input  logic             wb_valid,
   input  logic             wb_path,
   input  logic [REG_W-1:0] wb_reg,
   input  logic             div_event,
   input  logic             reconv_event,
   input  logic             reconv_path,
   output logic             diverged,
   output logic             home_path
);

   if (NUM_REGS < 2 || (NUM_REGS & (NUM_REGS - 1)) != 0) begin : g_bad_regs
      $fatal(1, "NUM_REGS must be a power of two of at least 2");
   end

   logic  div_q;
   path_e home_q;
   logic  div_fire;
   logic  reconv_fire;

   dps_mode_ctrl u_mode (
      .clk          (clk),
      .rst_n        (rst_n),
      .div_event    (div_event),
      .reconv_event (reconv_event),
      .reconv_path  (path_e'(reconv_path)),
      .diverged_q   (div_q),
      .home_q       (home_q),
      .div_fire     (div_fire),
      .reconv_fire  (reconv_fire)
   );

   // While converged every request is steered to the home scoreboard.
   path_e chk_eff, rsv_eff, wb_eff;
   assign chk_eff = div_q ? path_e'(chk_path) : home_q;
   assign rsv_eff = div_q ? path_e'(rsv_path) : home_q;
   assign wb_eff  = div_q ? path_e'(wb_path)  : home_q;

   logic [NUM_PATHS-1:0][NUM_REGS-1:0] pend_vec;
   logic [NUM_PATHS-1:0][NUM_REGS-1:0] shad_vec;
   logic [NUM_PATHS-1:0][NUM_REGS-1:0] nxt_vec;
   logic [NUM_REGS-1:0]                merged;

   assign merged = nxt_vec[0] | nxt_vec[1];

   for (genvar q = 0; q < NUM_PATHS; q++) begin : g_bank
      logic this_rsv, this_wb, this_keep, this_drop;
      assign this_rsv  = rsv_valid & (rsv_eff == path_e'(q));
      assign this_wb   = wb_valid  & (wb_eff  == path_e'(q));
      assign this_keep = reconv_fire & (reconv_path == 1'(q));
      assign this_drop = reconv_fire & (reconv_path != 1'(q));

      dps_bank #(.NUM_REGS(NUM_REGS)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .rsv_en     (this_rsv),
         .rsv_reg    (rsv_reg),
         .wb_en      (this_wb),
         .wb_reg     (wb_reg),
         .snap       (div_fire),
         .merge_load (this_keep),
         .merge_in   (merged),
         .clear_all  (this_drop),
         .pend_q     (pend_vec[q]),
         .shad_q     (shad_vec[q]),
         .pend_nxt   (nxt_vec[q])
      );
   end

   logic [NUM_OPS-1:0][REG_W-1:0] ops;
   assign ops = {chk_dst, chk_src_b, chk_src_a};

   dps_hazard #(.NUM_REGS(NUM_REGS), .NUM_OPS(NUM_OPS)) u_hazard (
      .own_pend   (pend_vec[chk_eff]),
      .other_shad (shad_vec[flip_path(chk_eff)]),
      .op_regs    (ops),
      .ok         (chk_ok)
   );

   assign diverged  = div_q;
   assign home_path = home_q;

endmodule

// File: rtl/dps_sb_chk.sv
module dps_sb_chk #(
   parameter int unsigned NUM_REGS = 32
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  diverged,
   input logic                  home_path,
   input logic [NUM_REGS-1:0]   pend0,
   input logic [NUM_REGS-1:0]   pend1,
   input logic [NUM_REGS-1:0]   shad0,
   input logic [NUM_REGS-1:0]   shad1
);

   // R8
   conv_no_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !diverged |-> (shad0 == '0 && shad1 == '0));

   // R4
   div_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(diverged) |-> ((home_path ? shad1 : shad0) == (home_path ? pend1 : pend0)));

   // R5
   no_shadow_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (diverged && $past(diverged)) |->
         ((shad0 & ~$past(shad0)) == '0 && (shad1 & ~$past(shad1)) == '0));

   // R8
   merge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(diverged) |-> ((home_path ? pend0 : pend1) == '0));

   // R3
   shadow_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((shad0 & ~pend0) == '0 && (shad1 & ~pend1) == '0));

   // R7
   idle_bank_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !diverged |-> ((home_path ? pend0 : pend1) == '0));

endmodule

bind dual_path_scoreboard dps_sb_chk #(.NUM_REGS(NUM_REGS)) u_dps_sb_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .diverged  (diverged),
   .home_path (home_path),
   .pend0     (pend_vec[0]),
   .pend1     (pend_vec[1]),
   .shad0     (shad_vec[0]),
   .shad1     (shad_vec[1])
);

// File: tb/dual_path_scoreboard_tb_top.sv
`timescale 1ns/1ps
module dual_path_scoreboard_tb_top;

   localparam int NREG = 32;
   localparam int RW   = $clog2(NREG);

   logic          clk = 1'b0;
   logic          rst_n;
   logic          chk_path;
   logic [RW-1:0] chk_src_a, chk_src_b, chk_dst;
   logic          chk_ok;
   logic          rsv_valid, rsv_path;
   logic [RW-1:0] rsv_reg;
   logic          wb_valid, wb_path;
   logic [RW-1:0] wb_reg;
   logic          div_event, reconv_event, reconv_path;
   logic          diverged, home_path;

   always #10 clk = ~clk;

   dual_path_scoreboard #(.NUM_REGS(NREG)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .chk_path(chk_path), .chk_src_a(chk_src_a), .chk_src_b(chk_src_b),
      .chk_dst(chk_dst), .chk_ok(chk_ok),
      .rsv_valid(rsv_valid), .rsv_path(rsv_path), .rsv_reg(rsv_reg),
      .wb_valid(wb_valid), .wb_path(wb_path), .wb_reg(wb_reg),
      .div_event(div_event), .reconv_event(reconv_event), .reconv_path(reconv_path),
      .diverged(diverged), .home_path(home_path)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   bit    done     = 1'b0;
   string cur_req  = "R1";

   // behavioural reference state
   bit mP [2][NREG];
   bit mS [2][NREG];
   bit mdiv;
   bit mhome;

   task automatic check(input bit got, input bit exp, input string what);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, what, got, exp, $time);
      end
   endtask

   function automatic bit model_ok();
      bit own, oth;
      int r [3];
      own = mdiv ? chk_path : mhome;
      oth = ~own;
      r[0] = int'(chk_src_a); r[1] = int'(chk_src_b); r[2] = int'(chk_dst);
      foreach (r[k]) if (mP[own][r[k]] || mS[oth][r[k]]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic idle();
      chk_path = 0; chk_src_a = 0; chk_src_b = 0; chk_dst = 0;
      rsv_valid = 0; rsv_path = 0; rsv_reg = 0;
      wb_valid = 0; wb_path = 0; wb_reg = 0;
      div_event = 0; reconv_event = 0; reconv_path = 0;
   endtask

   task automatic model_update();
      bit pn [2][NREG];
      bit re, we;
      int rp, wp;
      rp = mdiv ? int'(rsv_path) : int'(mhome);
      wp = mdiv ? int'(wb_path)  : int'(mhome);
      for (int q = 0; q < 2; q++)
         for (int i = 0; i < NREG; i++) begin
            re = rsv_valid && rp == q && int'(rsv_reg) == i;
            we = wb_valid  && wp == q && int'(wb_reg)  == i;
            pn[q][i] = (mP[q][i] && !we) || re;
            if (we) mS[q][i] = 1'b0;
         end
      if (!mdiv && div_event) begin
         for (int q = 0; q < 2; q++)
            for (int i = 0; i < NREG; i++) begin mP[q][i] = pn[q][i]; mS[q][i] = pn[q][i]; end
         mdiv = 1'b1;
      end else if (mdiv && reconv_event) begin
         for (int i = 0; i < NREG; i++) begin
            mP[reconv_path][i]  = pn[0][i] | pn[1][i];
            mP[~reconv_path][i] = 1'b0;
            mS[0][i] = 1'b0; mS[1][i] = 1'b0;
         end
         mdiv  = 1'b0;
         mhome = reconv_path;
      end else begin
         for (int q = 0; q < 2; q++)
            for (int i = 0; i < NREG; i++) mP[q][i] = pn[q][i];
      end
   endtask

   // compare at mid-low phase, then advance one clock
   task automatic step();
      #2;
      check(chk_ok, model_ok(), "chk_ok");
      check(diverged, mdiv, "diverged");
      check(home_path, mhome, "home_path");
      @(posedge clk);
      model_update();
      @(negedge clk);
   endtask

   task automatic expect_ok(input bit exp, input string what);
      #2;
      check(chk_ok, exp, what);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      idle();
      rst_n = 1'b0;
      mdiv = 0; mhome = 0;
      for (int q = 0; q < 2; q++)
         for (int i = 0; i < NREG; i++) begin mP[q][i] = 0; mS[q][i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      cur_req = "R1";
      chk_src_a = 3; chk_src_b = 17; chk_dst = 31;
      expect_ok(1'b1, "clean after reset");
      step();

      // R2: reserve blocks the same path
      cur_req = "R2";
      idle(); rsv_valid = 1; rsv_path = 0; rsv_reg = 5;
      step();
      idle(); chk_dst = 5;
      expect_ok(1'b0, "dst pending");
      step();

      // R7: converged, path tags ignored
      cur_req = "R7";
      idle(); chk_path = 1; chk_src_a = 5;
      expect_ok(1'b0, "tag ignored on check");
      rsv_valid = 1; rsv_path = 1; rsv_reg = 6;
      step();
      idle(); chk_path = 0; chk_src_b = 6;
      expect_ok(1'b0, "tagged reserve went home");
      step();

      // R11: each operand slot alone
      cur_req = "R11";
      idle(); chk_src_a = 6; chk_src_b = 1; chk_dst = 2;
      expect_ok(1'b0, "src_a slot");
      step();
      idle(); chk_src_a = 1; chk_src_b = 2; chk_dst = 3;
      expect_ok(1'b1, "no operand pending");
      step();

      // R9: reserve wins over writeback on same register
      cur_req = "R9";
      idle(); rsv_valid = 1; rsv_reg = 5; wb_valid = 1; wb_reg = 5;
      step();
      idle(); chk_src_a = 5;
      expect_ok(1'b0, "still pending after set+clear");
      step();

      // R4: split snapshots pending into shadow
      cur_req = "R4";
      idle(); div_event = 1;
      step();
      idle(); chk_path = 1; chk_src_a = 5;
      expect_ok(1'b0, "other path sees pre-split write");
      step();

      // R6: own pending still blocks after split
      cur_req = "R6";
      idle(); chk_path = 0; chk_dst = 6;
      expect_ok(1'b0, "own pre-split write");
      step();

      // R5: post-split write does not cross paths
      cur_req = "R5";
      idle(); rsv_valid = 1; rsv_path = 1; rsv_reg = 10;
      step();
      idle(); chk_path = 0; chk_src_b = 10;
      expect_ok(1'b1, "no false dependency");
      step();
      cur_req = "R6";
      idle(); chk_path = 1; chk_src_b = 10;
      expect_ok(1'b0, "own post-split write");
      step();

      // R3: tagged writeback clears pending and shadow
      cur_req = "R3";
      idle(); wb_valid = 1; wb_path = 0; wb_reg = 6;
      step();
      idle(); chk_path = 1; chk_src_a = 6;
      expect_ok(1'b1, "shadow cleared");
      step();
      idle(); chk_path = 0; chk_src_a = 6;
      expect_ok(1'b1, "pending cleared");
      step();

      // R10: second split ignored
      cur_req = "R10";
      idle(); div_event = 1; rsv_valid = 1; rsv_path = 1; rsv_reg = 12;
      step();
      idle(); chk_path = 0; chk_src_a = 12;
      expect_ok(1'b1, "no re-snapshot while diverged");
      step();

      // R8: rejoin into path 1
      cur_req = "R8";
      idle(); reconv_event = 1; reconv_path = 1;
      step();
      idle(); chk_path = 0; chk_src_a = 5;
      expect_ok(1'b0, "merged pre-split write");
      step();
      idle(); chk_dst = 10;
      expect_ok(1'b0, "merged path-1 write");
      step();
      idle(); wb_valid = 1; wb_path = 0; wb_reg = 5;
      step();
      idle(); chk_src_a = 5;
      expect_ok(1'b1, "writeback cleared home");
      step();

      // R10: rejoin while converged ignored
      cur_req = "R10";
      idle(); reconv_event = 1; reconv_path = 0;
      step();
      idle();
      #2; check(home_path, 1'b1, "home kept");
      step();

      // random mix over a small register window
      cur_req = "R2/R3/R4/R8";
      for (int n = 0; n < 3000; n++) begin
         idle();
         chk_path  = 1'($urandom);
         chk_src_a = RW'($urandom_range(0, 7));
         chk_src_b = RW'($urandom_range(0, 7));
         chk_dst   = RW'($urandom_range(0, 7));
         rsv_valid = ($urandom_range(0, 99) < 35);
         rsv_path  = 1'($urandom);
         rsv_reg   = RW'($urandom_range(0, 7));
         wb_valid  = ($urandom_range(0, 99) < 40);
         wb_path   = 1'($urandom);
         wb_reg    = RW'($urandom_range(0, 7));
         div_event    = ($urandom_range(0, 99) < 6);
         reconv_event = ($urandom_range(0, 99) < 6);
         reconv_path  = 1'($urandom);
         step();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule